// File: doc/BRIEF.md
# MSI Doorbell Device-ID Tagging Bridge

This block sits in front of the doorbell register of an interrupt translation unit. Each message-signalled-interrupt write that arrives on its write port becomes a (device ID, event ID) pair on its output port. The requester's identity is not carried on any sideband. It comes from the address that the requester writes to. A dedicated aliasing window gives every device one 32-bit word slot, and the word index of that slot is the device ID. A write that goes straight to the doorbell register is tagged with device ID zero.

The data word passes through unchanged as the event ID. Only whole, word-aligned 32-bit writes are translated. A malformed write to either region is dropped and raises a one-cycle error pulse. A write that hits neither region is accepted and discarded without comment.

The output uses a valid/ready handshake and holds one pending pair. While that pair is pending, the input stops accepting writes, so no write is lost and the order of writes is kept. The base of the window, the doorbell address and the width of the device-ID field are parameters. The window base must be aligned to the window size.

Top module: `msi_devid_tagger`

## Requirements
- R1: A synchronous active-high reset leaves `outValid` low, `errPulse` low and `inReady` high.
- R2: A write accepted inside the window, with all four strobes set and address bits [1:0] zero, raises `outValid` on the following cycle. `outDevId` then equals bits [DEVID_BITS+1:2] of the address offset from the window base.
- R3: The 32-bit write data appears unchanged on `outEvent`.
- R4: A well-formed write to the doorbell word address gives `outDevId` = 0.
- R5: The window covers exactly 4 << DEVID_BITS bytes. Its last word gives the all-ones device ID. The first byte past the window lies outside it.
- R6: A write to the window or the doorbell word is malformed if its address bits [1:0] are not zero or if its strobes are not 4'hF. Such a write is accepted and produces no output, and `errPulse` is high for exactly the cycle after acceptance.
- R7: A write outside both regions is accepted while `inReady` is high and produces neither output nor error, whatever its strobes.
- R8: While `outValid` is high and `outReady` is low, `outValid`, `outDevId` and `outEvent` hold their values.
- R9: `inReady` is low while a pair is pending. A write that waits is accepted after the handshake and comes out next, in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| inAddr | input | ADDR_W | Write byte address |
| inData | input | 32 | Write data (event ID) |
| inStrb | input | 4 | Byte strobes |
| inValid | input | 1 | Write request valid |
| inReady | output | 1 | Write accepted when high together with inValid |
| outDevId | output | DEVID_BITS | Tagged device ID |
| outEvent | output | 32 | Event ID |
| outValid | output | 1 | Pair valid |
| outReady | input | 1 | Translator takes the pair |
| errPulse | output | 1 | One-cycle pulse for a malformed write |

## Verification
Three kinds of wrong internal state show up at the ports within one cycle of the write that caused them. A wrong region decode or a wrong slice of the offset gives a wrong device ID, or a missing or spurious `outValid`. A wrong shape check gives an error pulse where output was expected, or the other way round. A pending flag that clears early or loads twice would overwrite held data under backpressure or pass a second write through. The stall sequence makes this visible as a changed `outDevId` or an out-of-order ID.

// File: rtl/msi_tag_pkg.sv
package msi_tag_pkg;
  typedef struct packed {
    logic load;   // capture a translated pair
    logic clear;  // pending pair consumed by the translator
  } tagCtl_t;
endpackage

// File: rtl/msi_tag_datapath.sv
module msi_tag_datapath
  import msi_tag_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DEVID_BITS = 6,
  parameter logic [ADDR_W-1:0] WIN_BASE = 32'h0001_0000,
  parameter logic [ADDR_W-1:0] BELL_ADDR = 32'h0000_2040
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [ADDR_W-1:0]     inAddr,
  input  logic [31:0]           inData,
  input  logic [3:0]            inStrb,
  input  tagCtl_t               ctl,
  input  logic                  pending,
  input  logic                  outReady,
  output logic                  goodHit,
  output logic                  badHit,
  output logic [DEVID_BITS-1:0] outDevId,
  output logic [31:0]           outEvent
);
  localparam int WIN_LOG = DEVID_BITS + 2;
  localparam logic [ADDR_W-1:0] OFS_MASK = (ADDR_W'(1) << WIN_LOG) - ADDR_W'(1);

  logic winHit, bellHit, shapeOk;
  logic [DEVID_BITS-1:0] devIdNext;

  always_comb begin
    winHit  = (inAddr & ~OFS_MASK) == WIN_BASE;
    bellHit = !winHit && (inAddr[ADDR_W-1:2] == BELL_ADDR[ADDR_W-1:2]);
    shapeOk = (inAddr[1:0] == 2'b00) && (inStrb == 4'hF);
    goodHit = (winHit || bellHit) && shapeOk;
    badHit  = (winHit || bellHit) && !shapeOk;
    devIdNext = winHit ? inAddr[WIN_LOG-1:2] : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      outDevId <= '0;
      outEvent <= '0;
    end else if (ctl.load) begin
      outDevId <= devIdNext;
      outEvent <= inData;
    end
  end

  // R2
  win_devid_chk: assert property (@(posedge clk) disable iff (rst)
    (ctl.load && winHit) |=> outDevId == $past(inAddr[WIN_LOG-1:2]));
  // R4
  bell_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (ctl.load && bellHit) |=> outDevId == '0);
  // R3
  event_pass_chk: assert property (@(posedge clk) disable iff (rst)
    ctl.load |=> outEvent == $past(inData));
  // R8
  hold_data_chk: assert property (@(posedge clk) disable iff (rst)
    (pending && !outReady) |=> ($stable(outDevId) && $stable(outEvent)));
endmodule

// File: rtl/msi_tag_ctrl.sv
module msi_tag_ctrl
  import msi_tag_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    inValid,
  input  logic    outReady,
  input  logic    goodHit,
  input  logic    badHit,
  output tagCtl_t ctl,
  output logic    pending,
  output logic    inReady,
  output logic    errPulse
);
  logic accept;

  always_comb begin
    inReady   = !pending;
    accept    = inValid && !pending;
    ctl.load  = accept && goodHit;
    ctl.clear = pending && outReady;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pending  <= 1'b0;
      errPulse <= 1'b0;
    end else begin
      errPulse <= accept && badHit;
      if (ctl.load) pending <= 1'b1;
      else if (ctl.clear) pending <= 1'b0;
    end
  end

  // R6
  err_no_out_chk: assert property (@(posedge clk) disable iff (rst)
    errPulse |-> !pending);
  // R8
  hold_valid_chk: assert property (@(posedge clk) disable iff (rst)
    (pending && !outReady) |=> pending);
  // R9
  load_sets_chk: assert property (@(posedge clk) disable iff (rst)
    ctl.load |=> pending);
  // R9
  rise_needs_req_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(pending) |-> $past(inValid));
endmodule

// File: rtl/msi_devid_tagger.sv
module msi_devid_tagger
  import msi_tag_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DEVID_BITS = 6,
  parameter logic [ADDR_W-1:0] WIN_BASE = 32'h0001_0000,
  parameter logic [ADDR_W-1:0] BELL_ADDR = 32'h0000_2040
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [ADDR_W-1:0]     inAddr,
  input  logic [31:0]           inData,
  input  logic [3:0]            inStrb,
  input  logic                  inValid,
  output logic                  inReady,
  output logic [DEVID_BITS-1:0] outDevId,
  output logic [31:0]           outEvent,
  output logic                  outValid,
  input  logic                  outReady,
  output logic                  errPulse
);
  tagCtl_t ctl;
  logic goodHit, badHit, pending;

  msi_tag_datapath #(
    .ADDR_W(ADDR_W), .DEVID_BITS(DEVID_BITS),
    .WIN_BASE(WIN_BASE), .BELL_ADDR(BELL_ADDR)
  ) u_dp (
    .clk(clk), .rst(rst), .inAddr(inAddr), .inData(inData), .inStrb(inStrb),
    .ctl(ctl), .pending(pending), .outReady(outReady),
    .goodHit(goodHit), .badHit(badHit),
    .outDevId(outDevId), .outEvent(outEvent)
  );

  msi_tag_ctrl u_ctrl (
    .clk(clk), .rst(rst), .inValid(inValid), .outReady(outReady),
    .goodHit(goodHit), .badHit(badHit), .ctl(ctl),
    .pending(pending), .inReady(inReady), .errPulse(errPulse)
  );

  assign outValid = pending;
endmodule

// File: tb/msi_devid_tagger_tb.sv
module msi_devid_tagger_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [31:0] inAddr = '0;
  logic [31:0] inData = '0;
  logic [3:0]  inStrb = '0;
  logic inValid = 1'b0;
  logic outReady = 1'b0;
  logic inReady, outValid, errPulse;
  logic [5:0] outDevId;
  logic [31:0] outEvent;
  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  msi_devid_tagger u_dut (
    .clk(clk), .rst(rst), .inAddr(inAddr), .inData(inData), .inStrb(inStrb),
    .inValid(inValid), .inReady(inReady), .outDevId(outDevId),
    .outEvent(outEvent), .outValid(outValid), .outReady(outReady),
    .errPulse(errPulse)
  );

  typedef struct packed {
    logic [31:0] addr;
    logic [31:0] data;
    logic [3:0]  strb;
    logic        expValid;
    logic [5:0]  expDev;
    logic        expErr;
  } vec_t;

  // window 0x10000..0x100FF, doorbell word 0x2040
  localparam vec_t TBL [10] = '{
    '{32'h0001_0000, 32'h0000_00A5, 4'hF, 1'b1, 6'd0,  1'b0},  // R2 first slot
    '{32'h0001_0014, 32'hDEAD_BEEF, 4'hF, 1'b1, 6'd5,  1'b0},  // R2 R3
    '{32'h0001_00FC, 32'h1234_5678, 4'hF, 1'b1, 6'd63, 1'b0},  // R5 last slot
    '{32'h0001_0100, 32'h0000_0001, 4'hF, 1'b0, 6'd0,  1'b0},  // R5 just past
    '{32'h0000_2040, 32'hCAFE_0007, 4'hF, 1'b1, 6'd0,  1'b0},  // R4 doorbell
    '{32'h0001_0012, 32'h0000_0002, 4'hF, 1'b0, 6'd0,  1'b1},  // R6 misaligned
    '{32'h0001_0010, 32'h0000_0003, 4'h7, 1'b0, 6'd0,  1'b1},  // R6 strobes
    '{32'h0000_2042, 32'h0000_0004, 4'hF, 1'b0, 6'd0,  1'b1},  // R6 doorbell
    '{32'h0000_5000, 32'h0000_0005, 4'h3, 1'b0, 6'd0,  1'b0},  // R7 outside
    '{32'h0001_FFFC, 32'h0000_0006, 4'hF, 1'b0, 6'd0,  1'b0}   // R7 outside
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drainOut();
    if (outValid) begin
      outReady = 1'b1;
      @(posedge clk);
      @(negedge clk);
      outReady = 1'b0;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%h expected=%h", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1
    chk(outValid == 1'b0, "R1 outValid", 32'(outValid), 0);
    chk(errPulse == 1'b0, "R1 errPulse", 32'(errPulse), 0);
    chk(inReady == 1'b1, "R1 inReady", 32'(inReady), 1);

    for (int i = 0; i < 10; i++) begin
      inAddr = TBL[i].addr; inData = TBL[i].data; inStrb = TBL[i].strb;
      inValid = 1'b1;
      chk(inReady == 1'b1, "R7 ready before write", 32'(inReady), 1);
      @(posedge clk);
      @(negedge clk);
      inValid = 1'b0;
      chk(outValid == TBL[i].expValid, "R2/R6/R7 outValid", 32'(outValid),
          32'(TBL[i].expValid));
      chk(errPulse == TBL[i].expErr, "R6 errPulse", 32'(errPulse),
          32'(TBL[i].expErr));
      if (TBL[i].expValid) begin
        chk(outDevId == TBL[i].expDev, "R2/R4/R5 devId", 32'(outDevId),
            32'(TBL[i].expDev));
        chk(outEvent == TBL[i].data, "R3 event", outEvent, TBL[i].data);
      end
      @(posedge clk);
      @(negedge clk);
      if (TBL[i].expErr)
        chk(errPulse == 1'b0, "R6 pulse one cycle", 32'(errPulse), 0);
      drainOut();
      chk(outValid == 1'b0, "R9 drained", 32'(outValid), 0);
    end

    // R8 R9 backpressure and ordering
    inAddr = 32'h0001_0008; inData = 32'h0000_0AAA; inStrb = 4'hF; inValid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    inAddr = 32'h0001_0020; inData = 32'h0000_0BBB;
    chk(inReady == 1'b0, "R9 ready low", 32'(inReady), 0);
    for (int k = 0; k < 3; k++) begin
      chk(outValid == 1'b1 && outDevId == 6'd2 && outEvent == 32'h0AAA,
          "R8 hold", {outValid, 7'd0, 18'd0, outDevId}, {1'b1, 25'd0, 6'd2});
      @(posedge clk);
      @(negedge clk);
    end
    outReady = 1'b1;
    @(posedge clk);
    @(negedge clk);
    outReady = 1'b0;
    chk(outValid == 1'b0, "R9 cleared", 32'(outValid), 0);
    chk(inReady == 1'b1, "R9 ready back", 32'(inReady), 1);
    @(posedge clk);
    @(negedge clk);
    inValid = 1'b0;
    chk(outValid == 1'b1 && outDevId == 6'd8, "R9 second in order",
        32'(outDevId), 8);
    chk(outEvent == 32'h0BBB, "R3 second event", outEvent, 32'h0BBB);
    drainOut();

    // R1 reset while pending
    inAddr = 32'h0000_2040; inData = 32'h7; inValid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    inValid = 1'b0;
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    chk(outValid == 1'b0, "R1 reset clears pending", 32'(outValid), 0);
    chk(inReady == 1'b1, "R1 reset ready", 32'(inReady), 1);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule